// File: doc/BRIEF.md
# Debug Scan-Chain Register Bank

A bank of debug registers inside a processor core that an external debugger reaches through one 38-bit data-register scan chain. Each scan shifts in a 32-bit data word, a 5-bit register address and a direction bit. At the same time it shifts out the word that was loaded into the chain when the scan began. A read takes two phases. One scan names the register, and its contents come out during the next scan. A write stores the data word when the scan ends.

Besides plain storage (debug control, debug status, vector catch and two watch units of six words each), the bank holds a two-way mailbox between the debugger and the core. The debugger fills one word and the core drains it. The core fills the other word and the debugger drains it. Two flags track occupancy: R means a host-to-core word is waiting, and W means a core-to-host word is waiting. Reading the mailbox through the chain takes the word, so a debugger that pulls words in a loop ends its last scan on the mailbox status address, which has no side effect. The scan strobes are qualified enables in the block's single clock domain.

Top module: `dbgsc_bank`

## Requirements
- R1: The chain holds 38 bits. Bits [31:0] are data and are shifted out first, least significant bit first, on `tdo`. Bits [36:32] are the register address. Bit 37 is the direction: 1 means write and 0 means read. One bit moves from `tdi` toward `tdo` per cycle with `shift_en` high.
- R2: Update with direction 0 selects an address. The next capture loads that register's value into data bits [31:0], so it comes out in the following scan. An update with direction 1 leaves the selected address unchanged.
- R3: The address map is as follows. Debug control is 0x00, debug status 0x01, vector catch 0x02, mailbox status 0x04 and mailbox data 0x05. Watch unit 0 occupies 0x08 to 0x0D and watch unit 1 occupies 0x10 to 0x15. Vector catch and watch words store all 32 bits.
- R4: Mailbox status reads bit 0 as R and bit 1 as W. Bits [27:2] read as zero and bits [31:28] read as the `VERSION` parameter. Host writes to this address change nothing.
- R5: A host write to mailbox data stores the word on `core_rdata` and sets R (`h2c_full`). A `core_rd` pulse clears R.
- R6: A `core_wr` pulse stores `core_wdata` and sets W (`c2h_full`). Every capture while mailbox data is selected loads that word and clears W. A capture while mailbox status is selected has no side effect.
- R7: Debug control keeps 6 bits, and bit 4 drives `mon_en`. Debug status keeps 5 bits. Higher bits of both read as zero.
- R8: Unmapped addresses (for example 0x03, 0x0E) read as zero and ignore writes.
- R9: When a host access and a core access hit the same flag in one cycle, the core wins. `core_rd` together with a host mailbox write leaves R at 0. `core_wr` together with a consuming capture leaves W at 1. In that case the capture carries the previous word.
- R10: Reset clears every register, both flags, the selected address (0x00) and the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture strobe: load data field from selected register |
| shift_en | input | 1 | Shift strobe: move chain one bit |
| upd_en | input | 1 | Update strobe: perform write or latch read address |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the chain (bit 0) |
| core_wr | input | 1 | Core puts a word for the host |
| core_wdata | input | 32 | Word the core puts |
| core_rd | input | 1 | Core takes the host word |
| core_rdata | output | 32 | Host-to-core word |
| h2c_full | output | 1 | R flag |
| c2h_full | output | 1 | W flag |
| mon_en | output | 1 | Monitor-mode enable from debug control bit 4 |

## Verification
Register and flag updates take effect at the clock edge of the strobe that causes them. Flags and `mon_en` are therefore sampled at the falling edge right after an update edge or a core pulse. A read scan's result is due one full scan later, in the 32 data bits that come out after the following capture edge. The driver queues that expected word when it starts each scan. The monitor compares it once the last data bit has been sampled, one bit per falling edge. Simultaneous-access cases place the core pulse in the exact capture or update cycle.

// File: rtl/dbgsc_pkg.sv
package dbgsc_pkg;
   localparam int ADDR_W     = 5;
   localparam int WATCH_REGS = 6;
   localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
   localparam logic [ADDR_W-1:0] A_STAT  = 5'h01;
   localparam logic [ADDR_W-1:0] A_VEC   = 5'h02;
   localparam logic [ADDR_W-1:0] A_MBSTS = 5'h04;
   localparam logic [ADDR_W-1:0] A_MBDAT = 5'h05;
endpackage

// File: rtl/dbgsc_shifter.sv
module dbgsc_shifter
   import dbgsc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              shift_en,
   input  logic              upd_en,
   input  logic              tdi,
   input  logic [DATA_W-1:0] cap_data,
   output logic              tdo,
   output logic              upd_wr,
   output logic [ADDR_W-1:0] upd_addr,
   output logic [DATA_W-1:0] upd_data,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam int CH_W  = DATA_W + ADDR_W + 1;
   localparam int DIR_B = CH_W - 1;

   logic [CH_W-1:0] chain;
   logic            upd_go;

   assign upd_go   = upd_en && !cap_en && !shift_en;
   assign upd_wr   = upd_go && chain[DIR_B];
   assign upd_addr = chain[DATA_W +: ADDR_W];
   assign upd_data = chain[DATA_W-1:0];
   assign tdo      = chain[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else if (cap_en) begin
         chain[DATA_W-1:0] <= cap_data;
      end else if (shift_en) begin
         chain <= {tdi, chain[CH_W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_addr <= '0;
      else if (upd_go && !chain[DIR_B])
         rd_addr <= chain[DATA_W +: ADDR_W];
   end

   // R1: serial input lands in the direction bit after one shift
   p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !cap_en) |=> (chain[DIR_B] == $past(tdi)));
   // R2: read update selects the scanned address
   p_rd_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_go && !chain[DIR_B]) |=> (rd_addr == $past(upd_addr)));
   // R2: write update keeps the selection
   p_wr_keeps_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_wr |=> $stable(rd_addr));
endmodule

// File: rtl/dbgsc_regfile.sv
module dbgsc_regfile
   import dbgsc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CTRL_W    = 6,
   parameter int STAT_W    = 5,
   parameter int MON_BIT   = 4,
   parameter int NUM_WATCH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              mon_en
);
   localparam int SLOT_W = $clog2(WATCH_REGS);

   if (NUM_WATCH < 1 || NUM_WATCH > 2) begin : g_bad_watch
      $error("NUM_WATCH must be 1 or 2");
   end
   if (CTRL_W > DATA_W || STAT_W > DATA_W || MON_BIT >= CTRL_W) begin : g_bad_width
      $error("control/status widths do not fit");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [STAT_W-1:0] stat_q;
   logic [DATA_W-1:0] vec_q;
   logic [NUM_WATCH-1:0]        unit_hit;
   logic [NUM_WATCH*DATA_W-1:0] unit_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         stat_q <= '0;
         vec_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
         if (wr_addr == A_STAT) stat_q <= wr_data[STAT_W-1:0];
         if (wr_addr == A_VEC)  vec_q  <= wr_data;
      end
   end

   assign mon_en = ctrl_q[MON_BIT];

   for (genvar u = 0; u < NUM_WATCH; u++) begin : g_unit
      logic [DATA_W-1:0] slot [WATCH_REGS];
      logic              wsel;
      logic              rsel;
      localparam logic [1:0] UNIT_TAG = 2'(u + 1);

      assign wsel = (wr_addr[4:3] == UNIT_TAG) && (wr_addr[2:0] < 3'(WATCH_REGS));
      assign rsel = (rd_addr[4:3] == UNIT_TAG) && (rd_addr[2:0] < 3'(WATCH_REGS));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < WATCH_REGS; k++) slot[k] <= '0;
         end else if (wr_en && wsel) begin
            slot[wr_addr[SLOT_W-1:0]] <= wr_data;
         end
      end

      assign unit_hit[u] = rsel;
      assign unit_rd[u*DATA_W +: DATA_W] = rsel ? slot[rd_addr[SLOT_W-1:0]] : '0;
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:  rd_data = DATA_W'(ctrl_q);
         A_STAT:  rd_data = DATA_W'(stat_q);
         A_VEC:   rd_data = vec_q;
         default: rd_data = '0;
      endcase
      for (int u = 0; u < NUM_WATCH; u++)
         if (unit_hit[u]) rd_data = unit_rd[u*DATA_W +: DATA_W];
   end

   // R7: monitor enable follows the written control bit
   p_mon_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL) |=> (mon_en == $past(wr_data[MON_BIT])));
endmodule

// File: rtl/dbgsc_mailbox.sv
module dbgsc_mailbox #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_put,
   input  logic [DATA_W-1:0] host_data,
   input  logic              host_take,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic              core_rd,
   output logic [DATA_W-1:0] h2c_word,
   output logic [DATA_W-1:0] c2h_word,
   output logic              h2c_full,
   output logic              c2h_full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h2c_word <= '0;
         h2c_full <= 1'b0;
      end else begin
         if (host_put) h2c_word <= host_data;
         if (core_rd)       h2c_full <= 1'b0;
         else if (host_put) h2c_full <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c2h_word <= '0;
         c2h_full <= 1'b0;
      end else begin
         if (core_wr) c2h_word <= core_wdata;
         if (core_wr)        c2h_full <= 1'b1;
         else if (host_take) c2h_full <= 1'b0;
      end
   end

   // R5: host write fills the word and raises R
   p_rflag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_put && !core_rd) |=> (h2c_full && h2c_word == $past(host_data)));
   // R6: consuming capture drops W
   p_consume_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_take && !core_wr) |=> !c2h_full);
   // R9: core read wins on R
   p_core_rd_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_rd |=> !h2c_full);
   // R9: core write wins on W
   p_core_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr |=> c2h_full);
endmodule

// File: rtl/dbgsc_bank.sv
module dbgsc_bank
   import dbgsc_pkg::*;
#(
   parameter int         DATA_W    = 32,
   parameter logic [3:0] VERSION   = 4'd1,
   parameter int         NUM_WATCH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              shift_en,
   input  logic              upd_en,
   input  logic              tdi,
   output logic              tdo,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic              core_rd,
   output logic [DATA_W-1:0] core_rdata,
   output logic              h2c_full,
   output logic              c2h_full,
   output logic              mon_en
);
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W too small for the version field");
   end

   logic              upd_wr;
   logic [ADDR_W-1:0] upd_addr;
   logic [DATA_W-1:0] upd_data;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] cap_data;
   logic [DATA_W-1:0] rf_rd;
   logic [DATA_W-1:0] c2h_word;
   logic [DATA_W-1:0] mb_status;
   logic              host_put;
   logic              host_take;

   dbgsc_shifter #(.DATA_W(DATA_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en),
      .upd_en(upd_en), .tdi(tdi), .cap_data(cap_data), .tdo(tdo),
      .upd_wr(upd_wr), .upd_addr(upd_addr), .upd_data(upd_data),
      .rd_addr(rd_addr)
   );

   dbgsc_regfile #(.DATA_W(DATA_W), .NUM_WATCH(NUM_WATCH)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(upd_wr), .wr_addr(upd_addr),
      .wr_data(upd_data), .rd_addr(rd_addr), .rd_data(rf_rd), .mon_en(mon_en)
   );

   assign host_put  = upd_wr && (upd_addr == A_MBDAT);
   assign host_take = cap_en && (rd_addr == A_MBDAT);

   dbgsc_mailbox #(.DATA_W(DATA_W)) i_mbox (
      .clk(clk), .rst_n(rst_n), .host_put(host_put), .host_data(upd_data),
      .host_take(host_take), .core_wr(core_wr), .core_wdata(core_wdata),
      .core_rd(core_rd), .h2c_word(core_rdata), .c2h_word(c2h_word),
      .h2c_full(h2c_full), .c2h_full(c2h_full)
   );

   always_comb begin
      mb_status = '0;
      mb_status[0] = h2c_full;
      mb_status[1] = c2h_full;
      mb_status[DATA_W-1 -: 4] = VERSION;
   end

   always_comb begin
      case (rd_addr)
         A_MBSTS: cap_data = mb_status;
         A_MBDAT: cap_data = c2h_word;
         default: cap_data = rf_rd;
      endcase
   end

   // R4: status capture leaves both flags untouched
   p_status_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && rd_addr == A_MBSTS && !core_wr && !core_rd && !upd_en)
      |=> ($stable(c2h_full) && $stable(h2c_full)));
endmodule

// File: tb/test_dbgsc_bank.sv
module test_dbgsc_bank;
   localparam logic [3:0] VER = 4'd3;
   localparam logic [31:0] VW = {VER, 28'h0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cap_en = 0, shift_en = 0, upd_en = 0, tdi = 0;
   logic tdo;
   logic core_wr = 0, core_rd = 0;
   logic [31:0] core_wdata = '0;
   logic [31:0] core_rdata;
   logic h2c_full, c2h_full, mon_en;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct { logic [31:0] val; string tag; } exp_t;
   exp_t exp_q[$];
   logic [31:0] got_word;
   event scan_done;

   always #10 clk = ~clk;

   dbgsc_bank #(.DATA_W(32), .VERSION(VER), .NUM_WATCH(2)) i_dbgsc_bank (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en),
      .upd_en(upd_en), .tdi(tdi), .tdo(tdo), .core_wr(core_wr),
      .core_wdata(core_wdata), .core_rd(core_rd), .core_rdata(core_rdata),
      .h2c_full(h2c_full), .c2h_full(c2h_full), .mon_en(mon_en)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected word as each scan completes
   initial begin
      forever begin
         @(scan_done);
         if (exp_q.size() == 0) begin
            chk(got_word, 32'hx, "queue empty");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(got_word, e.val, e.tag);
         end
      end
   end

   // driver: one full capture / shift / update sequence
   task automatic scan(input bit wr, input logic [4:0] a, input logic [31:0] d,
                       input logic [31:0] exp, input string tag,
                       input bit cw = 0, input logic [31:0] cwv = '0, input bit cr = 0);
      logic [37:0] vec;
      logic [37:0] got;
      exp_q.push_back('{val: exp, tag: tag});
      vec = {wr, a, d};
      @(negedge clk);
      cap_en = 1; core_wr = cw; core_wdata = cwv;
      @(negedge clk);
      cap_en = 0; core_wr = 0; shift_en = 1;
      for (int i = 0; i < 38; i++) begin
         tdi = vec[i];
         got[i] = tdo;
         @(negedge clk);
      end
      shift_en = 0; upd_en = 1; core_rd = cr;
      @(negedge clk);
      upd_en = 0; core_rd = 0;
      got_word = got[31:0];
      ->scan_done;
      @(negedge clk);
   endtask

   task automatic core_put(input logic [31:0] v);
      @(negedge clk); core_wr = 1; core_wdata = v;
      @(negedge clk); core_wr = 0;
   endtask

   task automatic core_take();
      @(negedge clk); core_rd = 1;
      @(negedge clk); core_rd = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk({31'b0, h2c_full}, 0, "R10 reset R flag");
      chk({31'b0, c2h_full}, 0, "R10 reset W flag");
      chk({31'b0, mon_en},   0, "R10 reset mon_en");
      chk({31'b0, tdo},      0, "R10 reset chain");

      scan(0, 5'h04, 0, 32'h0, "R10 reset select reads control 0");
      scan(1, 5'h00, 32'hFFFF_FFFF, VW, "R4 version field");
      chk({31'b0, mon_en}, 1, "R7 mon_en set");
      scan(0, 5'h00, 0, VW, "R2 write keeps selection");
      scan(0, 5'h01, 0, 32'h3F, "R7 control width 6");
      scan(1, 5'h01, 32'hFFFF_FFFF, 0, "R7 status reset");
      scan(0, 5'h08, 0, 32'h1F, "R7 status width 5");
      scan(1, 5'h08, 32'hA5A5_1234, 0, "R3 watch0 initial");
      scan(1, 5'h15, 32'h0BAD_F00D, 32'hA5A5_1234, "R3 watch0 value");
      scan(1, 5'h02, 32'h1357_9BDF, 32'hA5A5_1234, "R1 data bits");
      scan(0, 5'h15, 0, 32'hA5A5_1234, "R2 stale select");
      scan(0, 5'h02, 0, 32'h0BAD_F00D, "R3 watch1 last slot");
      scan(0, 5'h03, 0, 32'h1357_9BDF, "R3 vector catch");
      scan(1, 5'h03, 32'hFFFF_FFFF, 0, "R8 unmapped 0x03 reads zero");
      scan(1, 5'h0E, 32'hFFFF_FFFF, 0, "R8 unmapped after write");
      scan(0, 5'h0E, 0, 0, "R8 unmapped write ignored");
      scan(0, 5'h00, 0, 0, "R8 gap 0x0E reads zero");
      scan(1, 5'h00, 32'h0000_0000, 32'h3F, "R7 control readback");
      chk({31'b0, mon_en}, 0, "R7 mon_en cleared");

      // mailbox host to core
      scan(0, 5'h04, 0, 0, "R7 control cleared");
      scan(1, 5'h05, 32'hCAFE_0001, VW, "R4 status empty");
      chk({31'b0, h2c_full}, 1, "R5 R set by host write");
      chk(core_rdata, 32'hCAFE_0001, "R5 core sees word");
      scan(1, 5'h04, 32'hFFFF_FFFF, VW | 32'h1, "R4 status shows R");
      scan(0, 5'h04, 0, VW | 32'h1, "R4 status write ignored");
      core_take();
      chk({31'b0, h2c_full}, 0, "R5 R cleared by core read");

      // mailbox core to host
      core_put(32'h600D_BEEF);
      chk({31'b0, c2h_full}, 1, "R6 W set by core write");
      scan(0, 5'h05, 0, VW | 32'h2, "R4 status shows W");
      scan(0, 5'h04, 0, 32'h600D_BEEF, "R6 host reads word");
      chk({31'b0, c2h_full}, 0, "R6 W cleared by consume");
      scan(0, 5'h05, 0, VW, "R6 status capture no side effect");
      core_put(32'h1111_2222);
      scan(0, 5'h05, 0, 32'h1111_2222, "R6 consume first word");
      chk({31'b0, c2h_full}, 0, "R6 W cleared");
      core_put(32'h3333_4444);
      scan(0, 5'h04, 0, 32'h3333_4444, "R6 held select consumes again");
      chk({31'b0, c2h_full}, 0, "R6 W cleared again");

      // simultaneous accesses
      scan(0, 5'h05, 0, VW, "R4 status before collision");
      scan(0, 5'h04, 0, 32'h3333_4444, "R9 capture sees old word", 1, 32'h5555_6666);
      chk({31'b0, c2h_full}, 1, "R9 core write wins W");
      scan(1, 5'h05, 32'h7777_8888, VW | 32'h2, "R9 status W kept", 0, '0, 1);
      chk({31'b0, h2c_full}, 0, "R9 core read wins R");
      chk(core_rdata, 32'h7777_8888, "R9 host word stored");
      scan(0, 5'h05, 0, VW | 32'h2, "R9 status after collisions");
      scan(0, 5'h04, 0, 32'h5555_6666, "R9 newer core word");

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule